// File: doc/BRIEF.md
# Borrowed-Bus Memory Cycle Sequencer with Bursts

This block runs memory cycles on the external bus of an 8-bit processor after that bus has been taken over. Each command gives an operation, a start address, a length and a data byte. The block then drives the address, the active-low memory-request, read and write strobes, and an outgoing data byte with its output enable. For reads it samples the incoming data byte. Getting and giving back the bus is handled elsewhere.

There are five operations. The single operations are one read or one write. The burst operations are a write fed from a source stream, a fill with one constant byte, and a read that feeds a sink stream. During a burst the memory request stays low for the whole transfer. Only the read or write strobe pulses once per byte, and the address steps up by one after each byte. Strobe widths are fixed by parameters, and every command ends with a one-cycle completion pulse.

Top module: `membus_burst_seq`

## Requirements
- R1: While reset is held, and right after it, `mreqN`, `rdN` and `wrN` are high, `busDoe` is low, `cmdReady` is high, and `done`, `srcReady` and `snkValid` are low.
- R2: `cmdOp`=1 (single write) makes exactly one `wrN` pulse, low for WR_LOW (2) cycles. It carries `cmdAddr` and `cmdData`. `mreqN` is already low in the cycle before `wrN` falls, and `mreqN` rises only after a cycle in which both strobes are high. `cmdLen` is ignored.
- R3: `cmdOp`=0 (single read) makes exactly one `rdN` pulse, low for RD_LOW (3) cycles. `cmdLen` is ignored. The byte on `busDin` during the last low cycle appears on `rdData` by the time `done` pulses.
- R4: An operation with a nonzero length pulls `mreqN` low exactly once, and both strobes pulse only while `mreqN` is low.
- R5: The k-th byte of an operation (counting from 0) uses address `cmdAddr`+k modulo 2^19, and the address is steady while a strobe is low.
- R6: `cmdOp`=2 (burst write) takes one byte from the source stream for each byte of `cmdLen`. It waits for `srcValid`/`srcReady` before each strobe and drives the accepted byte during that strobe.
- R7: `cmdOp`=3 (burst fill) writes `cmdData` at each of `cmdLen` addresses and never raises `srcReady`.
- R8: `cmdOp`=4 (burst read) makes `cmdLen` read pulses. After each pulse the sampled byte is held on `rdData` with `snkValid` high until `snkReady`, and the next strobe waits for that acceptance.
- R9: A burst operation with `cmdLen`=0 produces no strobe and no `mreqN` low, and still pulses `done`.
- R10: Operation codes 5 to 7 behave like a zero-length burst.
- R11: `done` is a one-cycle pulse in a cycle where `mreqN` is high. `cmdReady` is low from acceptance until after `done`.
- R12: `rdN` and `wrN` are never low together. `busDoe` is high only while `mreqN` is low for a write-type operation (codes 1, 2, 3), so it is low during every read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command accepted (idle) |
| cmdOp | input | 3 | Operation code |
| cmdAddr | input | ADDR_W | Start address |
| cmdLen | input | LEN_W | Byte count for burst operations |
| cmdData | input | DATA_W | Write byte for single write and fill |
| srcValid | input | 1 | Source stream byte available |
| srcReady | output | 1 | Source stream byte taken |
| srcData | input | DATA_W | Source stream byte |
| snkValid | output | 1 | Sink stream byte available |
| snkReady | input | 1 | Sink stream byte taken |
| rdData | output | DATA_W | Last sampled read byte, sink stream data |
| done | output | 1 | Operation complete pulse |
| busAddr | output | ADDR_W | Bus address |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| busDout | output | DATA_W | Outgoing bus data |
| busDoe | output | 1 | Outgoing data enable |
| busDin | input | DATA_W | Incoming bus data |

## Verification
The bench uses the default parameters: a 19-bit address, a 16-bit length, 8-bit data, a write strobe of 2 cycles and a read strobe of 3. With these, start addresses at the top of the address space are reachable, so bursts that wrap past the last address and restart at zero get tested directly. The source and sink streams stall on fixed periodic patterns, so each burst meets cycles where the next strobe must wait for the handshake. A reset in the middle of a burst checks that the strobes and the request return to idle at once.

// File: rtl/membus_burst_pkg.sv
package membus_burst_pkg;

  localparam logic [2:0] OP_RD1  = 3'd0;
  localparam logic [2:0] OP_WR1  = 3'd1;
  localparam logic [2:0] OP_BWR  = 3'd2;
  localparam logic [2:0] OP_FILL = 3'd3;
  localparam logic [2:0] OP_BRD  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FETCH,
    ST_STROBE,
    ST_RECOV,
    ST_PUSH,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic loadSrc;
    logic capture;
    logic step;
  } dpCtl_t;

endpackage

// File: rtl/membus_burst_dp.sv
module membus_burst_dp
  import membus_burst_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] doutReg;
  logic [DATA_W-1:0] rdReg;

  // address counter: wraps naturally at 2^ADDR_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg <= '0;
    end else if (dpCtl.loadCmd) begin
      addrReg <= cmdAddr;
    end else if (dpCtl.step) begin
      addrReg <= addrReg + ADDR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doutReg <= '0;
    end else if (dpCtl.loadCmd) begin
      doutReg <= cmdData;
    end else if (dpCtl.loadSrc) begin
      doutReg <= srcData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdReg <= '0;
    end else if (dpCtl.capture) begin
      rdReg <= busDin;
    end
  end

  assign busAddr = addrReg;
  assign busDout = doutReg;
  assign rdData  = rdReg;

  // outgoing byte only moves on a load strobe (R6, R7)
  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dpCtl.loadCmd && !dpCtl.loadSrc) |=> $stable(busDout));

  // captured byte only moves on a capture strobe (R8)
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dpCtl.capture |=> $stable(rdData));

endmodule

// File: rtl/membus_burst_ctrl.sv
module membus_burst_ctrl
  import membus_burst_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [2:0]       cmdOp,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             srcValid,
  output logic             srcReady,
  output logic             snkValid,
  input  logic             snkReady,
  output logic             done,
  output logic             mreqN,
  output logic             rdN,
  output logic             wrN,
  output logic             busDoe,
  output dpCtl_t           dpCtl
);

  localparam int MAX_LOW = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int CNT_W   = $clog2(MAX_LOW + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_LOW - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_LOW - 1);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  seqState_e        state, stateNxt;
  logic [2:0]       opReg;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] effLen;
  logic [CNT_W-1:0] cnt;
  logic             isRead, isBurstWr, strobeLast, byteEnd, active;

  assign isRead     = (opReg == OP_RD1) || (opReg == OP_BRD);
  assign isBurstWr  = (opReg == OP_BWR);
  assign strobeLast = isRead ? (cnt == RD_LAST) : (cnt == WR_LAST);

  // singles are one byte, unknown codes are zero bytes
  always_comb begin
    unique case (cmdOp)
      OP_RD1, OP_WR1:          effLen = LEN_ONE;
      OP_BWR, OP_FILL, OP_BRD: effLen = cmdLen;
      default:                 effLen = '0;
    endcase
  end

  always_comb begin
    stateNxt = state;
    dpCtl    = '0;
    cmdReady = 1'b0;
    srcReady = 1'b0;
    snkValid = 1'b0;
    done     = 1'b0;
    byteEnd  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          dpCtl.loadCmd = 1'b1;
          stateNxt = (effLen == '0) ? ST_DONE : ST_SETUP;
        end
      end
      ST_SETUP: stateNxt = ST_FETCH;
      ST_FETCH: begin
        srcReady = isBurstWr;
        if (!isBurstWr || srcValid) begin
          dpCtl.loadSrc = isBurstWr;
          stateNxt = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (strobeLast) begin
          dpCtl.capture = isRead;
          stateNxt = (opReg == OP_BRD) ? ST_PUSH : ST_RECOV;
        end
      end
      ST_RECOV: byteEnd = 1'b1;
      ST_PUSH: begin
        snkValid = 1'b1;
        byteEnd  = snkReady;
      end
      ST_DONE: begin
        done = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (byteEnd) begin
      if (remain == LEN_ONE) begin
        stateNxt = ST_DONE;
      end else begin
        dpCtl.step = 1'b1;
        stateNxt = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      opReg  <= OP_RD1;
      remain <= '0;
      cnt    <= '0;
    end else begin
      state <= stateNxt;
      if (dpCtl.loadCmd) begin
        opReg  <= cmdOp;
        remain <= effLen;
      end else if (dpCtl.step) begin
        remain <= remain - LEN_ONE;
      end
      cnt <= (state == ST_STROBE) ? cnt + 1'b1 : '0;
    end
  end

  assign active = (state == ST_SETUP) || (state == ST_FETCH) || (state == ST_STROBE) ||
                  (state == ST_RECOV) || (state == ST_PUSH);
  assign mreqN  = !active;
  assign wrN    = !((state == ST_STROBE) && !isRead);
  assign rdN    = !((state == ST_STROBE) && isRead);
  assign busDoe = active && !isRead;

  // low-time counters kept only for the width checks
  logic [CNT_W:0] wrRun, rdRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrRun <= '0;
      rdRun <= '0;
    end else begin
      wrRun <= wrN ? '0 : wrRun + 1'b1;
      rdRun <= rdN ? '0 : rdRun + 1'b1;
    end
  end

  p_wr_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrN) |-> (wrRun == (CNT_W+1)'(WR_LOW)));

  p_rd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdN) |-> (rdRun == (CNT_W+1)'(RD_LOW)));

  p_mreq_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mreqN) |-> ($past(wrN) && $past(rdN)));

  p_strobe_in_mreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrN || !rdN) |-> !mreqN);

  p_sink_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snkValid && !snkReady) |=> snkValid);

  p_done_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mreqN && !cmdReady));

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wrN && !rdN));

  p_doe_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rdN |-> !busDoe);

endmodule

// File: rtl/membus_burst_seq.sv
module membus_burst_seq
  import membus_burst_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              srcValid,
  output logic              srcReady,
  input  logic [DATA_W-1:0] srcData,
  output logic              snkValid,
  input  logic              snkReady,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [ADDR_W-1:0] busAddr,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoe,
  input  logic [DATA_W-1:0] busDin
);

  dpCtl_t dpCtl;

  membus_burst_ctrl #(
    .LEN_W (LEN_W),
    .WR_LOW(WR_LOW),
    .RD_LOW(RD_LOW)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmdValid(cmdValid),
    .cmdReady(cmdReady),
    .cmdOp   (cmdOp),
    .cmdLen  (cmdLen),
    .srcValid(srcValid),
    .srcReady(srcReady),
    .snkValid(snkValid),
    .snkReady(snkReady),
    .done    (done),
    .mreqN   (mreqN),
    .rdN     (rdN),
    .wrN     (wrN),
    .busDoe  (busDoe),
    .dpCtl   (dpCtl)
  );

  membus_burst_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .dpCtl  (dpCtl),
    .cmdAddr(cmdAddr),
    .cmdData(cmdData),
    .srcData(srcData),
    .busDin (busDin),
    .busAddr(busAddr),
    .busDout(busDout),
    .rdData (rdData)
  );

  // address and outgoing data must not move under a low strobe (R5)
  p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wrN && $past(!wrN)) || (!rdN && $past(!rdN))) |-> $stable(busAddr));

  p_dout_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrN && $past(!wrN)) |-> $stable(busDout));

endmodule

// File: tb/membus_burst_seq_tb_top.sv
module membus_burst_seq_tb_top;
  import membus_burst_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = 3'd0;
  logic [18:0] cmdAddr = '0;
  logic [15:0] cmdLen = '0;
  logic [7:0]  cmdData = '0;
  logic        srcValid = 1'b0;
  logic        srcReady;
  logic [7:0]  srcData = '0;
  logic        snkValid;
  logic        snkReady = 1'b0;
  logic [7:0]  rdData;
  logic        done;
  logic [18:0] busAddr;
  logic        mreqN, rdN, wrN, busDoe;
  logic [7:0]  busDout;
  logic [7:0]  busDin;

  always #5 clk = ~clk;

  function automatic logic [7:0] memFn(input logic [18:0] a);
    return a[7:0] ^ {a[18:16], a[12:8]} ^ 8'h5C;
  endfunction

  assign busDin = memFn(busAddr);

  membus_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdData(cmdData),
    .srcValid(srcValid), .srcReady(srcReady), .srcData(srcData),
    .snkValid(snkValid), .snkReady(snkReady), .rdData(rdData),
    .done(done), .busAddr(busAddr), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
    .busDout(busDout), .busDoe(busDoe), .busDin(busDin)
  );

  // ---------------- monitor: owns stream drive and bus logs ----------------
  int monChecks = 0, monFails = 0;
  int stChecks = 0, stFails = 0;
  int cyc = 0;
  int wrTot = 0, rdTot = 0, mreqFalls = 0, doneTot = 0, srcAcc = 0, snkTot = 0;
  int wrRun = 0, rdRun = 0;
  logic [18:0] wrAddr [256];
  logic [7:0]  wrDat  [256];
  logic [18:0] rdAddr [256];
  logic [7:0]  snkBuf [256];
  logic [18:0] runAddr = '0;
  logic        prevM = 1'b1, prevW = 1'b1, prevR = 1'b1;
  logic        srcPend = 1'b0, snkPend = 1'b0;
  logic [7:0]  snkHeld = '0;
  logic [2:0]  curOp = 3'd0;

  task automatic mchk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    monChecks++;
    if (!ok) begin
      monFails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      monFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==",
               monChecks + stChecks + 1, monFails + stFails);
      $finish;
    end
    if (srcPend) srcAcc++;
    if (snkPend) begin
      snkBuf[snkTot[7:0]] = snkHeld;
      snkTot++;
    end
    srcValid = ((cyc % 3) != 1);
    srcData  = 8'h40 + srcAcc[7:0];
    snkReady = ((cyc % 4) != 2);
    srcPend  = srcValid && srcReady && rst_n;
    snkPend  = snkValid && snkReady && rst_n;
    snkHeld  = rdData;

    if (!rst_n) begin
      wrRun = 0; rdRun = 0;
      prevM = 1'b1; prevW = 1'b1; prevR = 1'b1;
    end else begin
      if (!wrN || !rdN) begin
        mchk(!(!wrN && !rdN), "R12 strobes overlap", {30'b0, wrN, rdN}, 32'h3);
        mchk(!mreqN, "R4 strobe outside mreq", {31'b0, mreqN}, 0);
      end
      if (!wrN) begin
        wrRun++;
        mchk(busDoe, "R12 doe off in write", {31'b0, busDoe}, 1);
        if (wrRun == 1) begin
          mchk(!prevM, "R2 mreq low before wr", {31'b0, prevM}, 0);
          wrAddr[wrTot[7:0]] = busAddr;
          wrDat[wrTot[7:0]]  = busDout;
          runAddr = busAddr;
        end else begin
          mchk(busAddr == runAddr, "R5 addr moved under wr", {13'b0, busAddr}, {13'b0, runAddr});
        end
      end else if (wrRun > 0) begin
        mchk(wrRun == 2, "R2 wr width", wrRun, 2);
        wrTot++;
        wrRun = 0;
      end
      if (!rdN) begin
        rdRun++;
        mchk(!busDoe, "R12 doe on in read", {31'b0, busDoe}, 0);
        if (rdRun == 1) begin
          rdAddr[rdTot[7:0]] = busAddr;
          runAddr = busAddr;
        end else begin
          mchk(busAddr == runAddr, "R5 addr moved under rd", {13'b0, busAddr}, {13'b0, runAddr});
        end
      end else if (rdRun > 0) begin
        mchk(rdRun == 3, "R3 rd width", rdRun, 3);
        rdTot++;
        rdRun = 0;
      end
      if (!mreqN && prevM) mreqFalls++;
      if (mreqN && !prevM)
        mchk(prevW && prevR, "R2 mreq rose with strobe low", {30'b0, prevW, prevR}, 32'h3);
      if (!mreqN && cmdReady)
        mchk(1'b0, "R11 ready while busy", 1, 0);
      if (srcReady && curOp != OP_BWR)
        mchk(1'b0, "R7 srcReady outside burst write", {29'b0, curOp}, OP_BWR);
      if (snkValid && curOp != OP_BRD)
        mchk(1'b0, "R8 snkValid outside burst read", {29'b0, curOp}, OP_BRD);
      if (done) begin
        mchk(mreqN, "R11 done with mreq low", {31'b0, mreqN}, 1);
        doneTot++;
      end
      prevM = mreqN; prevW = wrN; prevR = rdN;
    end
  end

  // ---------------- stimulus ----------------
  task automatic schk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    stChecks++;
    if (!ok) begin
      stFails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string tag);
    schk(mreqN && rdN && wrN, {tag, " strobes idle"}, {29'b0, mreqN, rdN, wrN}, 32'h7);
    schk(!busDoe, {tag, " doe"}, {31'b0, busDoe}, 0);
    schk(cmdReady, {tag, " cmdReady"}, {31'b0, cmdReady}, 1);
    schk(!done && !srcReady && !snkValid, {tag, " handshakes"},
         {29'b0, done, srcReady, snkValid}, 0);
  endtask

  task automatic runVec(input logic [2:0] op, input logic [18:0] addr,
                        input logic [7:0] len, input logic [7:0] dat);
    int w0, r0, m0, d0, s0, k0, n, guard;
    bit isRd;
    w0 = wrTot; r0 = rdTot; m0 = mreqFalls; d0 = doneTot; s0 = srcAcc; k0 = snkTot;
    case (op)
      OP_RD1, OP_WR1:          n = 1;
      OP_BWR, OP_FILL, OP_BRD: n = len;
      default:                 n = 0;
    endcase
    isRd = (op == OP_RD1) || (op == OP_BRD);
    curOp = op;
    cmdOp = op; cmdAddr = addr; cmdLen = {8'b0, len}; cmdData = dat;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    schk(!cmdReady, "R11 busy after accept", {31'b0, cmdReady}, 0);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    schk(!done && cmdReady, "R11 done single cycle", {30'b0, done, cmdReady}, 1);
    schk(doneTot - d0 == 1, "R11 done count", doneTot - d0, 1);
    schk(mreqFalls - m0 == ((n > 0) ? 1 : 0), "R4 R9 R10 mreq falls", mreqFalls - m0, (n > 0) ? 1 : 0);
    schk(wrTot - w0 == (isRd ? 0 : n), "R2 R7 R9 write strobes", wrTot - w0, isRd ? 0 : n);
    schk(rdTot - r0 == (isRd ? n : 0), "R3 R8 R9 read strobes", rdTot - r0, isRd ? n : 0);
    if (!isRd) begin
      for (int k = 0; k < n && k < (wrTot - w0); k++) begin
        logic [18:0] ea;
        logic [7:0]  ed;
        ea = addr + 19'(k);
        ed = (op == OP_BWR) ? 8'(8'h40 + s0 + k) : dat;
        schk(wrAddr[8'(w0 + k)] == ea, "R5 write address", {13'b0, wrAddr[8'(w0 + k)]}, {13'b0, ea});
        schk(wrDat[8'(w0 + k)] == ed, "R6 R7 write data", {24'b0, wrDat[8'(w0 + k)]}, {24'b0, ed});
      end
      if (op == OP_BWR) schk(srcAcc - s0 == n, "R6 source bytes taken", srcAcc - s0, n);
    end else begin
      for (int k = 0; k < n && k < (rdTot - r0); k++) begin
        logic [18:0] ea;
        ea = addr + 19'(k);
        schk(rdAddr[8'(r0 + k)] == ea, "R5 read address", {13'b0, rdAddr[8'(r0 + k)]}, {13'b0, ea});
      end
      if (op == OP_RD1) begin
        schk(rdData == memFn(addr), "R3 single read data", {24'b0, rdData}, {24'b0, memFn(addr)});
      end else begin
        schk(snkTot - k0 == n, "R8 sink byte count", snkTot - k0, n);
        for (int k = 0; k < n && k < (snkTot - k0); k++) begin
          logic [7:0] ed;
          ed = memFn(addr + 19'(k));
          schk(snkBuf[8'(k0 + k)] == ed, "R8 sink data", {24'b0, snkBuf[8'(k0 + k)]}, {24'b0, ed});
        end
      end
    end
  endtask

  // {op, addr, len, data}
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {3'd1, 19'h12345, 8'd0, 8'hA5},
    {3'd0, 19'h00100, 8'd0, 8'h00},
    {3'd3, 19'h7FFFE, 8'd4, 8'h3C},
    {3'd2, 19'h01000, 8'd3, 8'h00},
    {3'd4, 19'h7FFFF, 8'd3, 8'h00},
    {3'd3, 19'h00200, 8'd0, 8'h77},
    {3'd4, 19'h00300, 8'd0, 8'h00},
    {3'd5, 19'h00400, 8'd2, 8'h11},
    {3'd1, 19'h7FFFF, 8'd9, 8'h5A},
    {3'd2, 19'h40000, 8'd5, 8'h00},
    {3'd4, 19'h00010, 8'd6, 8'h00},
    {3'd7, 19'h00000, 8'd1, 8'h00},
    {3'd0, 19'h7FFFF, 8'd0, 8'h00}
  };

  initial begin
    // R1: during and after reset
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    for (int i = 0; i < NV; i++)
      runVec(VEC[i][37:35], VEC[i][34:16], VEC[i][15:8], VEC[i][7:0]);

    // R1: reset in the middle of a burst write drops everything at once
    curOp = OP_BWR;
    cmdOp = OP_BWR; cmdAddr = 19'h00500; cmdLen = 16'd6; cmdData = 8'h00;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (5) @(negedge clk);
    schk(!mreqN, "R4 burst in progress", {31'b0, mreqN}, 0);
    #1 rst_n = 1'b0;
    @(negedge clk);
    checkIdle("R1 mid-burst reset");
    #1 rst_n = 1'b1;
    @(negedge clk);
    checkIdle("R1 after mid-burst reset");

    // recovery after the reset
    runVec(OP_WR1, 19'h00ABC, 8'd0, 8'hC3);
    runVec(OP_FILL, 19'h0FFFF, 8'd2, 8'h99);

    $display("== %0d vectors applied, %0d miscompares ==",
             monChecks + stChecks, monFails + stFails);
    $finish;
  end

endmodule